// File: doc/BRIEF.md
# DMA Channel Cycle Sequencer

This block is the control engine that sits between the channel control words of a multi-channel DMA controller and its data mover. Every channel has two control words, a primary one and an alternate one. Each word packs a cycle type, a burst exponent and a count of transfers still to be done. A fixed-priority arbiter hands the mover to one channel at a time. Each grant covers a burst of up to 2^R transfers, and the arbiter decides again only after that burst is over. Each transfer is a strobe to the mover that is held until the mover acknowledges it. Each acknowledged strobe takes one off the count, and the new count is written straight back into the control word.

Three cycle types run. In basic cycles every burst needs its own request. In auto cycles a single request carries the whole count. Ping-pong cycles run one cycle on one structure and then turn to the other. When a burst ends with the count at zero, the sequencer does three things: it writes the cycle type back to invalid, it pulses the channel's done line for one cycle, and for ping-pong it swaps the channel's active structure. Cycle types with the top bit set are recognised but not run. A request to such a channel gives an error pulse and nothing more. Control words are loaded through a write port and read back through a combinational read port.

The FSM has three states. `S_IDLE` arbitrates. `S_MOVE` issues the burst's strobes. `S_CHECK` decides the outcome of the burst. The transitions are: *grant* (`S_IDLE`→`S_MOVE`, a channel is pending), *hold* (stay in `S_MOVE` while beats remain), *burst_end* (`S_MOVE`→`S_CHECK`, beat counter at zero), *rearb* (`S_CHECK`→`S_IDLE`, count not zero) and *complete* (`S_CHECK`→`S_IDLE`, count zero, with write-back and done).

Top module: `dma_seq_top`

## Requirements
- R1: Control word layout is bits [17:15] cycle type, [14:11] exponent R, [10:0] remaining count. The type codes are 000 invalid, 001 basic, 010 auto, 011 ping-pong. A channel whose active word is invalid never transfers, and its requests are dropped.
- R2: A grant moves min(2^min(R,10), count) transfers. Each cycle with xfer_req and xfer_ack both high is one transfer, and it takes one off the count stored in the active word.
- R3: Arbitration is fixed priority with channel 0 highest. It happens only between bursts, so a burst in progress is never cut short. Once a burst ends, a higher-priority pending channel is served before the next burst of the same cycle.
- R4: Basic: a request is latched until the channel is granted, and each burst consumes one request. With no new request, a half-finished cycle waits.
- R5: Auto: one request runs the whole count to completion, with arbitration between bursts.
- R6: When a burst leaves the count at zero, the active word's type is rewritten to 000 and done[c] is high for exactly one cycle.
- R7: Ping-pong: completion swaps the channel's active structure between primary and alternate. The next request runs the other structure, and if that structure is invalid the channel stays idle.
- R8: A request to a channel whose active type has bit 2 set gives a one-cycle err[c] pulse on the next clock edge and no transfer.
- R9: After reset all stored words are zero, the primary structure is active, and xfer_req, done and err are low.
- R10: While xfer_req is high and xfer_ack is low, xfer_req stays high and xfer_ch stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write a control word |
| cfg_ch | input | CH_W | Channel to write |
| cfg_alt | input | 1 | 1 selects the alternate structure |
| cfg_word | input | WORD_W | Control word to store |
| rd_ch | input | CH_W | Channel to read back |
| rd_alt | input | 1 | 1 reads the alternate structure |
| rd_word | output | WORD_W | Stored control word (combinational) |
| req | input | NCH | Per-channel request pulses |
| xfer_req | output | 1 | Transfer strobe to the data mover |
| xfer_ch | output | CH_W | Channel that owns the strobe |
| xfer_alt | output | 1 | Structure used by the strobe |
| xfer_ack | input | 1 | Mover accepts the strobe |
| done | output | NCH | One-cycle completion pulse per channel |
| err | output | NCH | One-cycle unsupported-type pulse per channel |

## Verification
The bench starts a long low-priority burst and raises a high-priority request while it runs. A sequencer that arbitrates on every transfer would mix the two channels inside the eight-beat burst, and one that forgot priority between bursts would finish the low channel first. For basic cycles it checks that a half-done cycle stalls with no fresh request, which a design treating every type as auto would not do. It also checks that an auto cycle finishes on one pulse. For ping-pong it runs both structures, then requests once more: a design that failed to swap, or failed to clear the type, would move data again. It stalls the acknowledge to catch strobes dropped or moved to another channel, and it requests an unsupported type to see that only an error pulse comes out.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int TYPE_W = 3;
    localparam int EXP_W  = 4;

    typedef logic [TYPE_W-1:0] cyc_t;

    localparam cyc_t CY_INVALID  = 3'b000;
    localparam cyc_t CY_BASIC    = 3'b001;
    localparam cyc_t CY_AUTO     = 3'b010;
    localparam cyc_t CY_PINGPONG = 3'b011;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MOVE,
        S_CHECK
    } seq_state_t;

    function automatic logic runnable(input cyc_t t);
        return (t != CY_INVALID) && !t[2];
    endfunction

    function automatic logic unsupported(input cyc_t t);
        return t[2];
    endfunction
endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  pend,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CH_W'(i);
        end
    end
endmodule

// File: rtl/dma_seq_store.sv
module dma_seq_store #(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int WORD_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CH_W-1:0]            cfg_ch,
    input  logic                       cfg_alt,
    input  logic [WORD_W-1:0]          cfg_word,
    input  logic                       upd_we,
    input  logic [CH_W-1:0]            upd_ch,
    input  logic                       upd_alt,
    input  logic [WORD_W-1:0]          upd_word,
    input  logic                       flip_we,
    input  logic [CH_W-1:0]            flip_ch,
    input  logic [CH_W-1:0]            rd_ch,
    input  logic                       rd_alt,
    output logic [WORD_W-1:0]          rd_word,
    output logic [NCH-1:0]             act_sel,
    output logic [NCH-1:0][WORD_W-1:0] act_word
);
    logic [NCH-1:0][WORD_W-1:0] pri_q;
    logic [NCH-1:0][WORD_W-1:0] alt_q;
    logic [NCH-1:0]             sel_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pri_q[c] <= '0;
                alt_q[c] <= '0;
                sel_q[c] <= 1'b0;
            end else begin
                if (upd_we && upd_ch == CH_W'(c)) begin
                    if (upd_alt) alt_q[c] <= upd_word;
                    else         pri_q[c] <= upd_word;
                end
                if (cfg_we && cfg_ch == CH_W'(c)) begin
                    if (cfg_alt) alt_q[c] <= cfg_word;
                    else         pri_q[c] <= cfg_word;
                end
                if (flip_we && flip_ch == CH_W'(c)) sel_q[c] <= ~sel_q[c];
            end
        end
        assign act_word[c] = sel_q[c] ? alt_q[c] : pri_q[c];
    end

    assign act_sel = sel_q;
    assign rd_word = rd_alt ? alt_q[rd_ch] : pri_q[rd_ch];
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 11,
    parameter int MAX_EXP = 10,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WORD_W = CNT_W + EXP_W + TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic              cfg_alt,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic              rd_alt,
    output logic [WORD_W-1:0] rd_word,
    input  logic [NCH-1:0]    req,
    output logic              xfer_req,
    output logic [CH_W-1:0]   xfer_ch,
    output logic              xfer_alt,
    input  logic              xfer_ack,
    output logic [NCH-1:0]    done,
    output logic [NCH-1:0]    err
);
    localparam int EXP_LO  = CNT_W;
    localparam int TYPE_LO = CNT_W + EXP_W;
    localparam int BEAT_W  = CNT_W + 1;

    seq_state_t                 state_q, state_d;
    logic [CH_W-1:0]            gch_q, gch_d;
    logic [BEAT_W-1:0]          beat_q, beat_d;
    logic [NCH-1:0]             req_lat_q, started_q, done_q, err_q;
    logic [NCH-1:0]             pend;
    logic [NCH-1:0]             act_sel;
    logic [NCH-1:0][WORD_W-1:0] act_word;
    logic                       arb_any;
    logic [CH_W-1:0]            arb_idx;
    logic                       upd_we, flip_we, cyc_end;
    logic [WORD_W-1:0]          upd_word, g_word;
    cyc_t                       g_type;
    logic [CNT_W-1:0]           g_cnt;

    function automatic logic [BEAT_W-1:0] burst_len(input logic [WORD_W-1:0] w);
        logic [EXP_W-1:0]  e;
        logic [BEAT_W-1:0] cap;
        logic [BEAT_W-1:0] cnt;
        e   = w[EXP_LO +: EXP_W];
        cap = (32'(e) > MAX_EXP) ? (BEAT_W'(1) << MAX_EXP) : (BEAT_W'(1) << e);
        cnt = {1'b0, w[CNT_W-1:0]};
        return (cnt < cap) ? cnt : cap;
    endfunction

    dma_seq_store #(.NCH(NCH), .CH_W(CH_W), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_ch   (cfg_ch),
        .cfg_alt  (cfg_alt),
        .cfg_word (cfg_word),
        .upd_we   (upd_we),
        .upd_ch   (gch_q),
        .upd_alt  (act_sel[gch_q]),
        .upd_word (upd_word),
        .flip_we  (flip_we),
        .flip_ch  (gch_q),
        .rd_ch    (rd_ch),
        .rd_alt   (rd_alt),
        .rd_word  (rd_word),
        .act_sel  (act_sel),
        .act_word (act_word)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_pend
        cyc_t ty;
        assign ty      = act_word[c][TYPE_LO +: TYPE_W];
        assign pend[c] = runnable(ty) &&
                         (req_lat_q[c] || req[c] || (started_q[c] && ty == CY_AUTO));
    end

    dma_seq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .pend (pend),
        .any  (arb_any),
        .idx  (arb_idx)
    );

    assign g_word = act_word[gch_q];
    assign g_type = g_word[TYPE_LO +: TYPE_W];
    assign g_cnt  = g_word[CNT_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        gch_d   = gch_q;
        beat_d  = beat_q;
        unique case (state_q)
            S_IDLE: begin
                if (arb_any) begin
                    state_d = S_MOVE;
                    gch_d   = arb_idx;
                    beat_d  = burst_len(act_word[arb_idx]);
                end
            end
            S_MOVE: begin
                if (beat_q == '0)  state_d = S_CHECK;
                else if (xfer_ack) beat_d  = beat_q - BEAT_W'(1);
            end
            S_CHECK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            gch_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            gch_q   <= gch_d;
            beat_q  <= beat_d;
        end
    end

    // outputs and write-back
    always_comb begin
        xfer_req = (state_q == S_MOVE) && (beat_q != '0);
        xfer_ch  = gch_q;
        xfer_alt = act_sel[gch_q];
        cyc_end  = (state_q == S_CHECK) && (g_cnt == '0);
        upd_we   = 1'b0;
        flip_we  = 1'b0;
        upd_word = g_word;
        if (xfer_req && xfer_ack) begin
            upd_we              = 1'b1;
            upd_word[CNT_W-1:0] = g_cnt - CNT_W'(1);
        end
        if (cyc_end) begin
            upd_we                        = 1'b1;
            upd_word[TYPE_LO +: TYPE_W]   = CY_INVALID;
            flip_we                       = (g_type == CY_PINGPONG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_lat_q <= '0;
            started_q <= '0;
            done_q    <= '0;
            err_q     <= '0;
        end else begin
            done_q <= '0;
            if (cyc_end) done_q[gch_q] <= 1'b1;
            for (int c = 0; c < NCH; c++) begin
                err_q[c] <= req[c] && unsupported(act_word[c][TYPE_LO +: TYPE_W]);
                if (state_q == S_IDLE && arb_any && arb_idx == CH_W'(c)) begin
                    req_lat_q[c] <= 1'b0;
                    if (act_word[c][TYPE_LO +: TYPE_W] == CY_AUTO) started_q[c] <= 1'b1;
                end else begin
                    if (req[c] && runnable(act_word[c][TYPE_LO +: TYPE_W]))
                        req_lat_q[c] <= 1'b1;
                    if (cyc_end && gch_q == CH_W'(c)) started_q[c] <= 1'b0;
                end
            end
        end
    end

    assign done = done_q;
    assign err  = err_q;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 11,
    parameter int WORD_W = 18,
    parameter int CH_W   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic                       xfer_req,
    input logic                       xfer_ack,
    input logic [CH_W-1:0]            xfer_ch,
    input logic [NCH-1:0]             done,
    input logic [NCH-1:0][WORD_W-1:0] act_word
);
    logic [WORD_W-1:0] cur_word;
    logic [CNT_W-1:0]  cur_cnt;
    logic [2:0]        cur_type;

    assign cur_word = act_word[xfer_ch];
    assign cur_cnt  = cur_word[CNT_W-1:0];
    assign cur_type = cur_word[WORD_W-1 -: 3];

    a_r10_hold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && xfer_ch == $past(xfer_ch)));

    a_r3_burst_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req)) |-> (xfer_ch == $past(xfer_ch)));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !cfg_we) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((done & $past(done)) == '0));

    a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    a_r1_runnable_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (cur_type != 3'b000 && !cur_type[2]));
endmodule

bind dma_seq_top dma_seq_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .WORD_W(WORD_W), .CH_W(CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .xfer_req (xfer_req),
    .xfer_ack (xfer_ack),
    .xfer_ch  (xfer_ch),
    .done     (done),
    .act_word (act_word)
);

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;
    localparam int NCH = 4;
    localparam int CW  = 11;
    localparam int WW  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_ch = '0;
    logic          cfg_alt = 1'b0;
    logic [WW-1:0] cfg_word = '0;
    logic [1:0]    rd_ch = '0;
    logic          rd_alt = 1'b0;
    logic [WW-1:0] rd_word;
    logic [NCH-1:0] req = '0;
    logic          xfer_req;
    logic [1:0]    xfer_ch;
    logic          xfer_alt;
    logic          xfer_ack = 1'b1;
    logic [NCH-1:0] done, err;

    int n_chk = 0, n_fail = 0;
    int xcnt[NCH], dcnt[NCH], ecnt[NCH];
    int dwide = 0, ewide = 0;
    int log_n = 0;
    int log_ch[64];
    int log_alt[64];
    logic [NCH-1:0] prev_done = '0, prev_err = '0;

    always #5 clk = ~clk;

    dma_seq_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_alt(cfg_alt), .cfg_word(cfg_word), .rd_ch(rd_ch), .rd_alt(rd_alt),
        .rd_word(rd_word), .req(req), .xfer_req(xfer_req), .xfer_ch(xfer_ch),
        .xfer_alt(xfer_alt), .xfer_ack(xfer_ack), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_req && xfer_ack) begin
                xcnt[xfer_ch]++;
                if (log_n < 64) begin
                    log_ch[log_n]  = int'(xfer_ch);
                    log_alt[log_n] = int'(xfer_alt);
                end
                log_n++;
            end
            for (int c = 0; c < NCH; c++) begin
                if (done[c]) dcnt[c]++;
                if (err[c])  ecnt[c]++;
                if (done[c] && prev_done[c]) dwide++;
                if (err[c] && prev_err[c])   ewide++;
            end
            prev_done = done;
            prev_err  = err;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk(input int ty, input int r, input int cnt);
        return {3'(ty), 4'(r), 11'(cnt)};
    endfunction

    task automatic wr(input int ch, input bit alt, input logic [WW-1:0] w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_alt = alt; cfg_word = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(posedge clk); #1; req = m;
        @(posedge clk); #1; req = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic peek(input int ch, input bit alt, output logic [WW-1:0] w);
        rd_ch = 2'(ch); rd_alt = alt; #1; w = rd_word;
    endtask

    task automatic clr();
        for (int c = 0; c < NCH; c++) begin
            xcnt[c] = 0; dcnt[c] = 0; ecnt[c] = 0;
        end
        dwide = 0; ewide = 0; log_n = 0;
    endtask

    task automatic t_reset();
        logic [WW-1:0] w;
        check(xfer_req == 1'b0, "R9 xfer_req", int'(xfer_req), 0);
        check(done == '0 && err == '0, "R9 done/err", int'({done, err}), 0);
        check(xfer_alt == 1'b0, "R9 primary active", int'(xfer_alt), 0);
        peek(3, 1'b1, w);
        check(w == '0, "R9 word cleared", int'(w), 0);
    endtask

    task automatic t_basic();
        logic [WW-1:0] w;
        clr();
        wr(1, 1'b0, mk(1, 1, 5));               // R1 basic, R=1, count 5
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 2, "R4 one burst per request", xcnt[1], 2);
        peek(1, 1'b0, w);
        check(int'(w[10:0]) == 3, "R2 count written back", int'(w[10:0]), 3);
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 4, "R4 second burst", xcnt[1], 4);
        check(dcnt[1] == 0, "R6 no early done", dcnt[1], 0);
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 5, "R2 last burst clipped", xcnt[1], 5);
        check(dcnt[1] == 1 && dwide == 0, "R6 done one cycle", dcnt[1], 1);
        peek(1, 1'b0, w);
        check(int'(w[17:15]) == 0, "R6 type invalid", int'(w[17:15]), 0);
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 5, "R1 invalid ignored", xcnt[1], 5);
    endtask

    task automatic t_auto();
        logic [WW-1:0] w;
        clr();
        wr(2, 1'b0, mk(2, 2, 10));              // R1 auto, R=2, count 10
        pulse(4'b0100); settle(60);
        check(xcnt[2] == 10, "R5 single request completes", xcnt[2], 10);
        check(dcnt[2] == 1, "R5 done", dcnt[2], 1);
        peek(2, 1'b0, w);
        check(int'(w[17:15]) == 0 && int'(w[10:0]) == 0, "R6 auto written back", int'(w), 0);
    endtask

    task automatic t_prio();
        bit ok;
        clr();
        wr(0, 1'b0, mk(2, 0, 2));
        wr(3, 1'b0, mk(2, 0, 2));
        pulse(4'b1001); settle(30);
        check(log_n == 4, "R3 both finish", log_n, 4);
        check(log_ch[0] == 0 && log_ch[1] == 0 && log_ch[2] == 3,
              "R3 channel 0 first", log_ch[2], 3);
        clr();
        wr(0, 1'b0, mk(2, 0, 2));
        wr(3, 1'b0, mk(2, 3, 16));
        pulse(4'b1000);
        for (int i = 0; i < 50 && log_n < 1; i++) @(negedge clk);
        pulse(4'b0001); settle(60);
        check(log_n == 18, "R3 total transfers", log_n, 18);
        ok = 1'b1;
        for (int i = 0; i < 18; i++) begin
            if (log_ch[i] != ((i == 8 || i == 9) ? 0 : 3)) ok = 1'b0;
        end
        check(ok, "R3 burst not cut, high channel between bursts", log_ch[8], 0);
    endtask

    task automatic t_pingpong();
        logic [WW-1:0] w;
        bit ok;
        clr();
        wr(1, 1'b0, mk(3, 2, 2));               // R1 ping-pong code 011
        wr(1, 1'b1, mk(3, 2, 3));
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 2 && log_alt[0] == 0 && log_alt[1] == 0,
              "R7 primary cycle", xcnt[1], 2);
        peek(1, 1'b0, w);
        check(int'(w[17:15]) == 0, "R7 primary invalidated", int'(w[17:15]), 0);
        pulse(4'b0010); settle(20);
        ok = (log_alt[2] == 1) && (log_alt[4] == 1);
        check(xcnt[1] == 5 && ok, "R7 alternate cycle", xcnt[1], 5);
        check(dcnt[1] == 2, "R7 two done pulses", dcnt[1], 2);
        pulse(4'b0010); settle(20);
        check(xcnt[1] == 5, "R7 stops on invalid", xcnt[1], 5);
    endtask

    task automatic t_unsup();
        clr();
        wr(2, 1'b0, mk(6, 1, 4));
        pulse(4'b0100); settle(10);
        check(ecnt[2] == 1 && ewide == 0, "R8 error pulse", ecnt[2], 1);
        check(xcnt[2] == 0, "R8 no transfer", xcnt[2], 0);
    endtask

    task automatic t_stall();
        clr();
        wr(0, 1'b0, mk(1, 2, 3));
        xfer_ack = 1'b0;
        pulse(4'b0001); settle(5);
        check(xfer_req == 1'b1 && xfer_ch == 2'd0, "R10 strobe held", int'(xfer_req), 1);
        check(xcnt[0] == 0, "R10 nothing moved", xcnt[0], 0);
        xfer_ack = 1'b1; settle(10);
        check(xcnt[0] == 3 && dcnt[0] == 1, "R10 drains after ack", xcnt[0], 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        settle(2);
        t_reset();
        t_basic();
        t_auto();
        t_prio();
        t_pingpong();
        t_unsup();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule